// File: doc/BRIEF.md
# Two-Channel Interrupt Vector Controller

This block decides when a dual-channel serial controller interrupts its host and which vector code the host reads back. Each channel carries a receive-interrupt flag, a transmit-interrupt flag and one under-service flag for each of them. Receive events always win. While a channel's receive interrupt is under service, a transmit interrupt on that channel stays pending and the vector keeps the receive code. The transmit interrupt is posted only once software has serviced or cleared the receive side.

Events come in as single-cycle strobes for each channel: a received byte, a break, a data-port read, a data-port write, a clear-transmit command and a reset-highest-under-service command. Level inputs carry the enables and the status-high selector. The block keeps a six-bit pending register and an eight-bit vector register. It also drives one registered interrupt line that is shared by both channels. In every two-bit port, bit 1 belongs to channel A and bit 0 to channel B. The receive-mode port packs channel A in bits [3:2] and channel B in bits [1:0].

Top module: `intvec_ctl`

## Requirements
- R1: After reset: irq is 0, vector is 0x00, pending is 0, rx_avail is 0 and brk_stat is 0.
- R2: A receive strobe on a channel does all of the following:
  - sets that channel's rx_avail bit;
  - sets its receive pending bit (bit 5 for A, bit 2 for B);
  - marks the receive side as under service;
  - loads the receive vector code.
- R3: The vector codes depend on stat_hi.
  - With stat_hi=0: receive A 0x0C, transmit A 0x08, receive B 0x04, transmit B 0x00, none 0x06.
  - With stat_hi=1: receive A 0x30, transmit A 0x10, receive B 0x20, transmit B 0x00, none 0x60.
- R4: A data-port write makes the channel's transmit interrupt pending.
  - If that channel has no receive interrupt under service, the write also loads the transmit vector code.
  - Under the same condition, it sets the transmit pending bit (bit 4 for A, bit 1 for B) if tx_ie for that channel is 1.
  - Otherwise the transmit interrupt stays pending and vector and pending are left unchanged.
- R5: A data-port read does the following, in order:
  - clears rx_avail, the receive interrupt, receive service and the receive pending bit;
  - loads the none code;
  - re-posts the channel's transmit interrupt as in R4, if one is pending.
- R6: A clear-transmit command clears the transmit interrupt, its service flag and its pending bit, and loads the none code. It then re-posts the channel's receive interrupt as in R2, if one is pending.
- R7: A reset-highest-under-service command acts on the receive side first.
  - If receive is under service, it clears that flag and re-posts a pending transmit interrupt.
  - Otherwise it clears the transmit service flag, which leaves vector and pending unchanged.
- R8: irq is the OR of one term per channel.
  - Transmit term: tx_ie and the transmit interrupt.
  - Receive term: rx_mode equal to 01 or 10, and the receive interrupt.
  - Break term: brk_ie and brk_stat.
  - irq is a register that updates on the same edge as the state it reflects.
- R9: Strobes in one cycle are applied in this order, with channel A before channel B at each stage: reads, receive strobes and breaks, clear-transmit commands, writes, service resets.
- R10: A break strobe sets brk_stat, which stays set until reset. Pending bits 0 and 3 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 2 | Byte received strobe |
| brk_evt | input | 2 | Break detected strobe |
| data_rd | input | 2 | Data-port read strobe |
| data_wr | input | 2 | Data-port write strobe |
| clr_tx_cmd | input | 2 | Clear transmit interrupt command |
| rst_ius_cmd | input | 2 | Reset highest under service command |
| tx_ie | input | 2 | Transmit interrupt enable |
| rx_mode | input | 4 | Receive interrupt mode, A in [3:2], B in [1:0] |
| brk_ie | input | 2 | Break interrupt enable |
| stat_hi | input | 1 | Selects the high placement of the vector |
| irq | output | 1 | Shared registered interrupt |
| vector | output | 8 | Current vector code |
| pending | output | 6 | Pending register |
| rx_avail | output | 2 | Receive data available |
| brk_stat | output | 2 | Break status |

## Verification
The internal flags that are not visible directly are the under-service and interrupt flags. A wrong value in one of them shows up at the ports on the first edge of a later write, read, clear or service-reset: the vector or pending register then moves to a value the restated model does not expect, or fails to move. A stale interrupt flag also shows on irq on the very edge of the stimulus. A long pseudo-random stream of overlapping strobes under changing enables and placements catches the divergence within one cycle of the event that exposes it.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NCH   = 2;
  localparam int VEC_W = 8;
  localparam int PND_W = 3 * NCH;

  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_TX   = 2'd1;
  localparam logic [1:0] K_RX   = 2'd2;

  typedef struct packed {
    logic rx_int;
    logic tx_int;
    logic rx_svc;
    logic tx_svc;
    logic rx_av;
    logic brk;
  } chan_t;

  typedef struct packed {
    chan_t [NCH-1:0]   ch;
    logic [VEC_W-1:0]  vec;
    logic [PND_W-1:0]  pend;
  } ctl_t;

  function automatic logic [VEC_W-1:0] vec_code(input logic is_a,
                                                input logic [1:0] kind,
                                                input logic hi);
    logic [VEC_W-1:0] v;
    case ({hi, is_a, kind})
      {1'b0, 1'b1, K_RX}: v = 8'h0C;
      {1'b0, 1'b1, K_TX}: v = 8'h08;
      {1'b0, 1'b0, K_RX}: v = 8'h04;
      {1'b1, 1'b1, K_RX}: v = 8'h30;
      {1'b1, 1'b1, K_TX}: v = 8'h10;
      {1'b1, 1'b0, K_RX}: v = 8'h20;
      default: v = (kind == K_NONE) ? (hi ? 8'h60 : 8'h06) : 8'h00;
    endcase
    return v;
  endfunction

  function automatic ctl_t post_rx(input ctl_t s, input int c, input logic hi);
    ctl_t r = s;
    r.ch[c].rx_int   = 1'b1;
    r.ch[c].rx_svc   = 1'b1;
    r.pend[3*c+2]    = 1'b1;
    r.vec            = vec_code(c == 1, K_RX, hi);
    return r;
  endfunction

  function automatic ctl_t post_tx(input ctl_t s, input int c, input logic hi,
                                   input logic ie);
    ctl_t r = s;
    r.ch[c].tx_int = 1'b1;
    if (!r.ch[c].rx_svc) begin
      r.ch[c].tx_svc = 1'b1;
      if (ie) r.pend[3*c+1] = 1'b1;
      r.vec = vec_code(c == 1, K_TX, hi);
    end
    return r;
  endfunction

  function automatic ctl_t drop_rx(input ctl_t s, input int c, input logic hi,
                                   input logic ie);
    ctl_t r = s;
    r.ch[c].rx_int = 1'b0;
    r.ch[c].rx_svc = 1'b0;
    r.pend[3*c+2]  = 1'b0;
    r.vec          = vec_code(c == 1, K_NONE, hi);
    if (r.ch[c].tx_int) r = post_tx(r, c, hi, ie);
    return r;
  endfunction

  function automatic ctl_t drop_tx(input ctl_t s, input int c, input logic hi);
    ctl_t r = s;
    r.ch[c].tx_int = 1'b0;
    r.ch[c].tx_svc = 1'b0;
    r.pend[3*c+1]  = 1'b0;
    r.vec          = vec_code(c == 1, K_NONE, hi);
    if (r.ch[c].rx_int) r = post_rx(r, c, hi);
    return r;
  endfunction

  function automatic ctl_t svc_done(input ctl_t s, input int c, input logic hi,
                                    input logic ie);
    ctl_t r = s;
    if (r.ch[c].rx_svc) begin
      r.ch[c].rx_svc = 1'b0;
      if (r.ch[c].tx_int) r = post_tx(r, c, hi, ie);
    end else if (r.ch[c].tx_svc) begin
      r.ch[c].tx_svc = 1'b0;
    end
    return r;
  endfunction

  function automatic logic chan_req(input chan_t ch, input logic tie,
                                    input logic [1:0] rmode, input logic bie);
    return (tie && ch.tx_int) ||
           ((rmode == 2'b01 || rmode == 2'b10) && ch.rx_int) ||
           (bie && ch.brk);
  endfunction
endpackage

// File: rtl/ivc_seq.sv
module ivc_seq
  import ivc_pkg::*;
(
  input  ctl_t           cur,
  input  logic [NCH-1:0] rx_byte,
  input  logic [NCH-1:0] brk_evt,
  input  logic [NCH-1:0] data_rd,
  input  logic [NCH-1:0] data_wr,
  input  logic [NCH-1:0] clr_tx_cmd,
  input  logic [NCH-1:0] rst_ius_cmd,
  input  logic [NCH-1:0] tx_ie,
  input  logic           stat_hi,
  output ctl_t           nxt
);
  always_comb begin
    ctl_t s;
    s = cur;
    for (int c = NCH-1; c >= 0; c--)
      if (data_rd[c]) begin
        s.ch[c].rx_av = 1'b0;
        s = drop_rx(s, c, stat_hi, tx_ie[c]);
      end
    for (int c = NCH-1; c >= 0; c--) begin
      if (rx_byte[c]) begin
        s.ch[c].rx_av = 1'b1;
        s = post_rx(s, c, stat_hi);
      end
      if (brk_evt[c]) s.ch[c].brk = 1'b1;
    end
    for (int c = NCH-1; c >= 0; c--)
      if (clr_tx_cmd[c]) s = drop_tx(s, c, stat_hi);
    for (int c = NCH-1; c >= 0; c--)
      if (data_wr[c]) begin
        s.ch[c].tx_int = 1'b0;
        s = post_tx(s, c, stat_hi, tx_ie[c]);
      end
    for (int c = NCH-1; c >= 0; c--)
      if (rst_ius_cmd[c]) s = svc_done(s, c, stat_hi, tx_ie[c]);
    nxt = s;
  end
endmodule

// File: rtl/ivc_irq.sv
module ivc_irq
  import ivc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_t [NCH-1:0]  ch_nxt,
  input  logic [NCH-1:0]   tx_ie,
  input  logic [2*NCH-1:0] rx_mode,
  input  logic [NCH-1:0]   brk_ie,
  output logic             irq
);
  logic [NCH-1:0] req;

  for (genvar c = 0; c < NCH; c++) begin : g_req
    assign req[c] = chan_req(ch_nxt[c], tx_ie[c], rx_mode[2*c +: 2], brk_ie[c]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |req;

  logic all_masked;
  assign all_masked = ~|tx_ie && ~|brk_ie &&
                      (rx_mode[1:0] == 2'b00 || rx_mode[1:0] == 2'b11) &&
                      (rx_mode[3:2] == 2'b00 || rx_mode[3:2] == 2'b11);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    all_masked |=> !irq);
endmodule

// File: rtl/intvec_ctl.sv
module intvec_ctl
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_byte,
  input  logic [1:0] brk_evt,
  input  logic [1:0] data_rd,
  input  logic [1:0] data_wr,
  input  logic [1:0] clr_tx_cmd,
  input  logic [1:0] rst_ius_cmd,
  input  logic [1:0] tx_ie,
  input  logic [3:0] rx_mode,
  input  logic [1:0] brk_ie,
  input  logic       stat_hi,
  output logic       irq,
  output logic [7:0] vector,
  output logic [5:0] pending,
  output logic [1:0] rx_avail,
  output logic [1:0] brk_stat
);
  ctl_t ctl_q, ctl_d;

  ivc_seq u_seq (
    .cur(ctl_q), .rx_byte(rx_byte), .brk_evt(brk_evt), .data_rd(data_rd),
    .data_wr(data_wr), .clr_tx_cmd(clr_tx_cmd), .rst_ius_cmd(rst_ius_cmd),
    .tx_ie(tx_ie), .stat_hi(stat_hi), .nxt(ctl_d)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;

  ivc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ch_nxt(ctl_d.ch), .tx_ie(tx_ie),
    .rx_mode(rx_mode), .brk_ie(brk_ie), .irq(irq)
  );

  assign vector  = ctl_q.vec;
  assign pending = ctl_q.pend;

  logic [1:0] rx_svc_q;
  logic [5:0] strobe_cnt;
  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign rx_avail[c] = ctl_q.ch[c].rx_av;
    assign brk_stat[c] = ctl_q.ch[c].brk;
    assign rx_svc_q[c] = ctl_q.ch[c].rx_svc;
  end
  assign strobe_cnt = 6'($countones({rx_byte, brk_evt, data_rd, data_wr,
                                     clr_tx_cmd, rst_ius_cmd}));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r2_rx_sets_avail: assert property (@(posedge clk) disable iff (!rst_n)
      rx_byte[c] |=> rx_avail[c]);
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd[c] && !rx_byte[c] |=> !rx_avail[c]);
    a_r10_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      brk_stat[c] |=> brk_stat[c]);
    a_r4_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr[c] && rx_svc_q[c] && strobe_cnt == 6'd1 |=> $stable(vector) && $stable(pending));
    a_r6_clr_tx_bit: assert property (@(posedge clk) disable iff (!rst_n)
      clr_tx_cmd[c] && strobe_cnt == 6'd1 |=> !pending[3*c+1]);
  end

  a_r10_ext_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr != 2'b00 |=> pending[0] == 1'b0 && pending[3] == 1'b0);
endmodule

// File: tb/sim_intvec_ctl.sv
module sim_intvec_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rx_byte = '0, brk_evt = '0, data_rd = '0, data_wr = '0;
  logic [1:0] clr_tx_cmd = '0, rst_ius_cmd = '0, tx_ie = '0, brk_ie = '0;
  logic [3:0] rx_mode = '0;
  logic       stat_hi = 1'b0;
  logic       irq;
  logic [7:0] vector;
  logic [5:0] pending;
  logic [1:0] rx_avail, brk_stat;

  always #5 clk = ~clk;

  intvec_ctl u0 (.*);

  int n_chk = 0, n_bad = 0;

  // reference state
  logic [1:0] m_rxi, m_txi, m_rsv, m_tsv, m_av, m_brk;
  logic [7:0] m_vec;
  logic [5:0] m_pnd;
  logic       m_irq;

  function automatic logic [7:0] code(input int c, input bit rx, input bit none, input bit hi);
    if (none) return hi ? 8'h60 : 8'h06;
    if (hi)   return 8'((rx ? 32 : 0) + (c * 16));
    return 8'((c * 8) + (rx ? 4 : 0));
  endfunction

  task automatic m_reset();
    m_rxi = 0; m_txi = 0; m_rsv = 0; m_tsv = 0; m_av = 0; m_brk = 0;
    m_vec = 0; m_pnd = 0; m_irq = 0;
  endtask

  task automatic m_set_rx(input int c);
    m_rxi[c] = 1; m_rsv[c] = 1; m_pnd[c*3+2] = 1; m_vec = code(c, 1, 0, stat_hi);
  endtask

  task automatic m_set_tx(input int c);
    m_txi[c] = 1;
    if (m_rsv[c] == 0) begin
      m_tsv[c] = 1;
      if (tx_ie[c]) m_pnd[c*3+1] = 1;
      m_vec = code(c, 0, 0, stat_hi);
    end
  endtask

  task automatic m_clr_rx(input int c);
    m_rxi[c] = 0; m_rsv[c] = 0; m_pnd[c*3+2] = 0; m_vec = code(c, 0, 1, stat_hi);
    if (m_txi[c]) m_set_tx(c);
  endtask

  task automatic m_clr_tx(input int c);
    m_txi[c] = 0; m_tsv[c] = 0; m_pnd[c*3+1] = 0; m_vec = code(c, 0, 1, stat_hi);
    if (m_rxi[c]) m_set_rx(c);
  endtask

  // R9 order of application
  task automatic m_step();
    for (int c = 1; c >= 0; c--) if (data_rd[c]) begin m_av[c] = 0; m_clr_rx(c); end
    for (int c = 1; c >= 0; c--) begin
      if (rx_byte[c]) begin m_av[c] = 1; m_set_rx(c); end
      if (brk_evt[c]) m_brk[c] = 1;
    end
    for (int c = 1; c >= 0; c--) if (clr_tx_cmd[c]) m_clr_tx(c);
    for (int c = 1; c >= 0; c--) if (data_wr[c]) begin m_txi[c] = 0; m_set_tx(c); end
    for (int c = 1; c >= 0; c--) if (rst_ius_cmd[c]) begin
      if (m_rsv[c]) begin m_rsv[c] = 0; if (m_txi[c]) m_set_tx(c); end
      else m_tsv[c] = 0;
    end
    m_irq = 0;
    for (int c = 0; c < 2; c++) begin
      logic [1:0] md;
      md = rx_mode[2*c +: 2];
      if ((tx_ie[c] & m_txi[c]) | ((md[1] ^ md[0]) & m_rxi[c]) | (brk_ie[c] & m_brk[c]))
        m_irq = 1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R8 irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R3 vector", vector, m_vec);
    chk("R2 pending", {2'd0, pending}, {2'd0, m_pnd});
    chk("R5 rx_avail", {6'd0, rx_avail}, {6'd0, m_av});
    chk("R10 brk_stat", {6'd0, brk_stat}, {6'd0, m_brk});
  endtask

  task automatic clear_strobes();
    rx_byte = 0; brk_evt = 0; data_rd = 0; data_wr = 0; clr_tx_cmd = 0; rst_ius_cmd = 0;
  endtask

  // apply current strobes for one edge, then compare at the following negedge
  task automatic cyc();
    m_step();
    @(negedge clk);
    chk_all();
    clear_strobes();
  endtask

  task automatic do_reset();
    rst_n = 0; m_reset(); clear_strobes();
    @(negedge clk);
    rst_n = 1;
  endtask

  int unsigned rs = 32'h1357_9BDF;
  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    m_reset();
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 vector", vector, 8'h00);
    chk("R1 pending", {2'd0, pending}, 8'd0);
    chk("R1 rx_avail", {6'd0, rx_avail}, 8'd0);
    chk("R1 brk_stat", {6'd0, brk_stat}, 8'd0);
    rst_n = 1;
    @(negedge clk);

    // directed, low placement
    tx_ie = 2'b11; rx_mode = 4'b0101; stat_hi = 0;
    rx_byte = 2'b10; cyc();
    chk("R2 vector rxA", vector, 8'h0C); chk("R2 pending", {2'd0, pending}, 8'h20);
    chk("R8 irq rx", {7'd0, irq}, 8'd1);
    data_wr = 2'b10; cyc();
    chk("R4 held vector", vector, 8'h0C); chk("R4 held pending", {2'd0, pending}, 8'h20);
    rst_ius_cmd = 2'b10; cyc();
    chk("R7 txA posted", vector, 8'h08); chk("R7 pending", {2'd0, pending}, 8'h30);
    data_rd = 2'b10; cyc();
    chk("R5 rx_avail", {6'd0, rx_avail}, 8'd0); chk("R5 tx reposted", vector, 8'h08);
    chk("R5 pending", {2'd0, pending}, 8'h10);
    clr_tx_cmd = 2'b10; cyc();
    chk("R6 none low", vector, 8'h06); chk("R6 pending", {2'd0, pending}, 8'h00);
    data_wr = 2'b01; cyc();
    chk("R3 txB low", vector, 8'h00); chk("R4 pending txB", {2'd0, pending}, 8'h02);
    rx_byte = 2'b01; cyc();
    chk("R3 rxB low", vector, 8'h04);
    stat_hi = 1;
    clr_tx_cmd = 2'b01; cyc();
    chk("R6 rx reposted high", vector, 8'h20);
    data_rd = 2'b01; cyc();
    chk("R3 none high", vector, 8'h60);

    // R9 same cycle: receive first blocks transmit on channel A
    do_reset();
    stat_hi = 1; tx_ie = 2'b11;
    rx_byte = 2'b10; data_wr = 2'b10; cyc();
    chk("R9 rx wins vector", vector, 8'h30); chk("R9 pending", {2'd0, pending}, 8'h20);
    rst_ius_cmd = 2'b10; cyc();
    chk("R3 txA high", vector, 8'h10);

    // R10 break, R8 break term
    brk_ie = 2'b01; rx_mode = 4'b0000; tx_ie = 2'b00;
    do_reset();
    brk_evt = 2'b01; cyc();
    chk("R10 brk", {6'd0, brk_stat}, 8'h01); chk("R8 brk irq", {7'd0, irq}, 8'd1);
    brk_ie = 2'b00; cyc();
    chk("R8 brk masked", {7'd0, irq}, 8'd0);

    // sweep: random overlapping strobes under changing configuration
    for (int blk = 0; blk < 48; blk++) begin
      do_reset();
      for (int k = 0; k < 60; k++) begin
        int unsigned r;
        if (k % 20 == 0) begin
          r = rnd();
          tx_ie = r[1:0]; rx_mode = r[5:2]; brk_ie = r[7:6] & {2{r[8]}}; stat_hi = r[9];
        end
        r = rnd();
        for (int b = 0; b < 12; b++) begin
          logic on;
          on = (rnd() % 6) == 0;
          case (b / 2)
            0: rx_byte[b%2]     = on;
            1: brk_evt[b%2]     = on & r[0] & r[1];
            2: data_rd[b%2]     = on;
            3: data_wr[b%2]     = on;
            4: clr_tx_cmd[b%2]  = on;
            default: rst_ius_cmd[b%2] = on;
          endcase
        end
        cyc();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule